// File: doc/BRIEF.md
# WFI Clock-Gating Controller

This block decides, every cycle, whether the clock of a core-plus-L2 cluster may run. When the core reports that it is waiting for an interrupt, and the power sequencer reports that it is idle, the controller moves into a gated state and registers a gate bit. That bit turns the cluster's clock enable off. The enable drives an integrated clock-gate cell, which is outside this block.

The clock comes back in three cases. The first is a reset, which can be the external reset or a low software reset from the SoC. The second is a raised bit on the 8-bit interrupt-source vector. The third is pending incoming interconnect traffic on the snoop, response or data channel. Interrupt wakes and traffic wakes go through two separate awake states. The machine returns to normal only after the core has left WFI. An incoming snoop also bypasses the registered gate, so the enable rises in the same cycle the snoop appears. A power-down gate from the sequencer also holds the enable low, and the snoop bypass overrides it. A build-time parameter can disable WFI gating entirely.

Top module: `wfi_clock_gate_ctrl`

## Requirements
- R1: Reset is asynchronous and active when `rst` is high or `soft_rst_n` is low. While reset is active, the machine is in its normal state, the gate bit is 0, and `clk_en` is 1 unless `pd_gate` is high.
- R2: From the normal state, a clock edge with `core_wfi` and `seq_idle` both high enters the gated state. The gate bit is set on the following edge, so `clk_en` falls after the second such edge.
- R3: With `seq_idle` low, the normal state is never left, whatever the value of `core_wfi`.
- R4: The gated state is left only when an interrupt source or a pending flit is present. A change of `seq_idle` or `core_wfi` alone does not release it.
- R5: Any bit of `irq_src` releases the gated state into the interrupt-awake state. Bit 7 is machine software, then machine timer, machine external, supervisor external, two non-maskable lines, debug, and bit 0 is message-signalled-interrupt valid. The gate bit clears one edge after the exit, so `clk_en` rises after the second edge.
- R6: With no interrupt present, a pending flit on any of `snp_pend`, `rsp_pend` or `dat_pend` releases the gated state into the flit-awake state. When both an interrupt and a flit are present, the interrupt takes precedence.
- R7: Both awake states stay where they are while `core_wfi` is high, so gating cannot start again. They return to normal on the first edge with `core_wfi` low.
- R8: `clk_en` equals (NOT gate AND NOT `pd_gate`) OR `snp_pend`, without any register in the path. A snoop therefore re-enables the clock in the same cycle, even over the power-down gate. A response or data flit does not.
- R9: With the parameter `GATE_EN` set to 0, the gate bit stays 0, so `clk_en` equals NOT `pd_gate` OR `snp_pend`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | External reset, active high, asynchronous |
| soft_rst_n | input | 1 | SoC software reset, active low, asynchronous |
| core_wfi | input | 1 | Core is in wait-for-interrupt |
| seq_idle | input | 1 | Power sequencer is in its idle (normal) state |
| snp_pend | input | 1 | Snoop flit pending |
| rsp_pend | input | 1 | Response flit pending |
| dat_pend | input | 1 | Data flit pending |
| irq_src | input | 8 | Interrupt sources, encoded as in R5 |
| pd_gate | input | 1 | Power-down clock gate from the sequencer |
| clk_en | output | 1 | Clock enable for the gate cell |

## Verification
Inputs change half a period before a rising edge and are held while `clk_en` is sampled shortly after that edge. Each sample therefore shows the registers updated by that edge together with the combinational terms of the same inputs. Entering and leaving the gate each take two edges, one for the state and one for the gate bit. The vector table gives the expected enable for every edge, and the rows around each transition record both the unchanged cycle and the changed one. The snoop bypass, the power-down gate and reset are due with no edge at all. The directed tests sample those a fraction of a period after the stimulus, before any edge arrives.

// File: rtl/wfi_cg_pkg.sv
package wfi_cg_pkg;

    localparam int IRQ_W = 8;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_GATED     = 2'd1,
        ST_IRQ_WAKE  = 2'd2,
        ST_FLIT_WAKE = 2'd3
    } cg_state_t;

    // Interrupt source vector, MSB first
    typedef struct packed {
        logic m_soft;
        logic m_timer;
        logic m_ext;
        logic s_ext;
        logic nmi_hi;
        logic nmi_lo;
        logic dbg;
        logic msi_vld;
    } irq_vec_t;

    typedef struct packed {
        logic snp;
        logic rsp;
        logic dat;
    } flit_pend_t;

    function automatic logic irq_any(input irq_vec_t v);
        return |v;
    endfunction

    function automatic logic flit_any(input flit_pend_t f);
        return f.snp | f.rsp | f.dat;
    endfunction

    function automatic logic is_awake(input cg_state_t s);
        return (s == ST_IRQ_WAKE) || (s == ST_FLIT_WAKE);
    endfunction

endpackage

// File: rtl/wfi_cg_fsm.sv
module wfi_cg_fsm
    import wfi_cg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_any,
    input  logic       core_wfi,
    input  logic       seq_idle,
    input  irq_vec_t   irq,
    input  flit_pend_t flit,
    output cg_state_t  state
);

    cg_state_t state_nxt;
    logic      wake_irq;
    logic      wake_flit;

    assign wake_irq  = irq_any(irq);
    assign wake_flit = flit_any(flit);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: begin
                if (core_wfi && seq_idle) state_nxt = ST_GATED;
            end
            ST_GATED: begin
                if (wake_irq)       state_nxt = ST_IRQ_WAKE;
                else if (wake_flit) state_nxt = ST_FLIT_WAKE;
            end
            ST_IRQ_WAKE, ST_FLIT_WAKE: begin
                if (!core_wfi) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or posedge rst_any) begin
        if (rst_any) state <= ST_RUN;
        else         state <= state_nxt;
    end

    p_enter_gate_r2: assert property (@(posedge clk) disable iff (rst_any)
        (state == ST_RUN && core_wfi && seq_idle) |=> (state == ST_GATED));

    p_idle_required_r3: assert property (@(posedge clk) disable iff (rst_any)
        (state == ST_RUN && !seq_idle) |=> (state == ST_RUN));

    p_hold_gated_r4: assert property (@(posedge clk) disable iff (rst_any)
        (state == ST_GATED && !wake_irq && !wake_flit) |=> (state == ST_GATED));

    p_irq_wake_r5: assert property (@(posedge clk) disable iff (rst_any)
        (state == ST_GATED && wake_irq) |=> (state == ST_IRQ_WAKE));

    p_flit_wake_r6: assert property (@(posedge clk) disable iff (rst_any)
        (state == ST_GATED && !wake_irq && wake_flit) |=> (state == ST_FLIT_WAKE));

    p_awake_hold_r7: assert property (@(posedge clk) disable iff (rst_any)
        (is_awake(state) && core_wfi) |=> $stable(state));

    p_awake_exit_r7: assert property (@(posedge clk) disable iff (rst_any)
        (is_awake(state) && !core_wfi) |=> (state == ST_RUN));

endmodule

// File: rtl/wfi_cg_gate.sv
module wfi_cg_gate
    import wfi_cg_pkg::*;
#(
    parameter bit GATE_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst_any,
    input  cg_state_t state,
    input  logic      pd_gate,
    input  logic      snp_pend,
    output logic      wfi_gate,
    output logic      clk_en
);

    generate
        if (GATE_EN) begin : g_gate
            always_ff @(posedge clk or posedge rst_any) begin
                if (rst_any) wfi_gate <= 1'b0;
                else         wfi_gate <= (state == ST_GATED);
            end
        end else begin : g_nogate
            always_ff @(posedge clk or posedge rst_any) begin
                if (rst_any) wfi_gate <= 1'b0;
                else         wfi_gate <= 1'b0;
            end
            p_never_gate_r9: assert property (@(posedge clk) disable iff (rst_any)
                !wfi_gate);
        end
    endgenerate

    assign clk_en = (!wfi_gate && !pd_gate) || snp_pend;

    if (GATE_EN) begin : g_chk
        p_gate_tracks_state_r2: assert property (@(posedge clk) disable iff (rst_any)
            wfi_gate |-> $past(state == ST_GATED));
    end

endmodule

// File: rtl/wfi_clock_gate_ctrl.sv
module wfi_clock_gate_ctrl
    import wfi_cg_pkg::*;
#(
    parameter bit GATE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst_n,
    input  logic             core_wfi,
    input  logic             seq_idle,
    input  logic             snp_pend,
    input  logic             rsp_pend,
    input  logic             dat_pend,
    input  logic [IRQ_W-1:0] irq_src,
    input  logic             pd_gate,
    output logic             clk_en
);

    logic       rst_any;
    irq_vec_t   irq;
    flit_pend_t flit;
    cg_state_t  state;
    logic       wfi_gate;

    assign rst_any = rst || !soft_rst_n;
    assign irq     = irq_vec_t'(irq_src);
    assign flit    = '{snp: snp_pend, rsp: rsp_pend, dat: dat_pend};

    wfi_cg_fsm u_fsm (
        .clk      (clk),
        .rst_any  (rst_any),
        .core_wfi (core_wfi),
        .seq_idle (seq_idle),
        .irq      (irq),
        .flit     (flit),
        .state    (state)
    );

    wfi_cg_gate #(.GATE_EN(GATE_EN)) u_gate (
        .clk      (clk),
        .rst_any  (rst_any),
        .state    (state),
        .pd_gate  (pd_gate),
        .snp_pend (snp_pend),
        .wfi_gate (wfi_gate),
        .clk_en   (clk_en)
    );

    p_snoop_bypass_r8: assert property (@(posedge clk) disable iff (rst_any)
        snp_pend |-> clk_en);

    p_reset_state_r1: assert property (@(posedge clk)
        rst_any |-> (state == ST_RUN && !wfi_gate));

endmodule

// File: tb/wfi_clock_gate_ctrl_tb_top.sv
module wfi_clock_gate_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 30;

    // Row layout: [14]wfi [13]idle [12]snp [11]rsp [10]dat [9]pd [8:1]irq [0]expected clk_en
    localparam logic [14:0] VEC [NVEC] = '{
        15'b0_1_0_0_0_0_00000000_1, // 0  idle running
        15'b1_1_0_0_0_0_00000000_1, // 1  enter gated, gate not yet set
        15'b1_1_0_0_0_0_00000000_0, // 2  gate set
        15'b1_1_0_0_0_0_00000000_0, // 3  held
        15'b1_1_1_0_0_0_00000000_1, // 4  snoop: bypass + flit wake
        15'b1_1_0_0_0_0_00000000_1, // 5  gate cleared
        15'b1_1_0_0_0_0_00000000_1, // 6  flit-awake, no regate
        15'b0_1_0_0_0_0_00000000_1, // 7  leave wfi -> run
        15'b1_1_0_0_0_0_00000000_1, // 8  enter gated
        15'b1_1_0_0_0_0_00000000_0, // 9  gated
        15'b1_1_0_0_0_0_10000000_0, // 10 irq bit7 wake, gate still on
        15'b1_1_0_0_0_0_00000000_1, // 11 gate cleared
        15'b1_1_0_0_0_0_00000000_1, // 12 irq-awake holds
        15'b0_1_0_0_0_0_00000000_1, // 13 back to run
        15'b1_0_0_0_0_0_00000000_1, // 14 wfi without idle
        15'b1_0_0_0_0_0_00000000_1, // 15 still running
        15'b1_1_0_0_0_0_00000000_1, // 16 enter gated
        15'b1_1_0_0_0_0_00000000_0, // 17 gated
        15'b1_0_0_0_0_0_00000000_0, // 18 idle drop does not release
        15'b1_1_0_1_0_0_00000000_0, // 19 response flit wake, no bypass
        15'b1_1_0_0_0_0_00000000_1, // 20 gate cleared
        15'b0_1_0_0_0_0_00000000_1, // 21 run
        15'b1_1_0_0_0_0_00000000_1, // 22 enter gated
        15'b1_1_0_0_0_0_00000000_0, // 23 gated
        15'b1_1_0_0_1_0_00000001_0, // 24 data flit + irq bit0
        15'b1_1_0_0_0_0_00000000_1, // 25 awake
        15'b0_1_0_0_0_0_00000000_1, // 26 run
        15'b0_1_0_0_0_1_00000000_0, // 27 power-down gate
        15'b0_1_1_0_0_1_00000000_1, // 28 snoop overrides power-down
        15'b0_1_0_0_0_0_00000000_1  // 29 released
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       soft_rst_n;
    logic       core_wfi;
    logic       seq_idle;
    logic       snp_pend;
    logic       rsp_pend;
    logic       dat_pend;
    logic [7:0] irq_src;
    logic       pd_gate;
    logic       clk_en;
    logic       clk_en_off;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wfi_clock_gate_ctrl #(.GATE_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .soft_rst_n(soft_rst_n), .core_wfi(core_wfi),
        .seq_idle(seq_idle), .snp_pend(snp_pend), .rsp_pend(rsp_pend),
        .dat_pend(dat_pend), .irq_src(irq_src), .pd_gate(pd_gate), .clk_en(clk_en)
    );

    wfi_clock_gate_ctrl #(.GATE_EN(1'b0)) dut_nogate_i (
        .clk(clk), .rst(rst), .soft_rst_n(soft_rst_n), .core_wfi(core_wfi),
        .seq_idle(seq_idle), .snp_pend(snp_pend), .rsp_pend(rsp_pend),
        .dat_pend(dat_pend), .irq_src(irq_src), .pd_gate(pd_gate), .clk_en(clk_en_off)
    );

    function automatic string row_tag(input int i);
        case (i)
            1, 2, 8, 9, 16, 17, 22, 23: return "R2";
            3, 18:                       return "R4";
            4, 28:                       return "R8";
            10, 11, 24:                  return "R5";
            19, 20:                      return "R6";
            5, 6, 7, 12, 13, 25, 26:     return "R7";
            14, 15:                      return "R3";
            27:                          return "R8";
            default:                     return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [14:0] v);
        core_wfi = v[14];
        seq_idle = v[13];
        snp_pend = v[12];
        rsp_pend = v[11];
        dat_pend = v[10];
        pd_gate  = v[9];
        irq_src  = v[8:1];
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        soft_rst_n = 1'b1;
        drive(15'b0_1_0_0_0_0_00000000_0);
        repeat (3) @(posedge clk);
        #2;
        check("R1", clk_en, 1'b1, "enable during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1", clk_en, 1'b1, "enable after reset");

        // vector table: R2..R8 on the gating instance, R9 on the non-gating one
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(posedge clk);
            #2;
            check(row_tag(i), clk_en, VEC[i][0], $sformatf("table row %0d", i));
            check("R9", clk_en_off, !VEC[i][9] || VEC[i][12], $sformatf("no-gate row %0d", i));
        end

        // R1: soft reset low releases gating asynchronously
        @(negedge clk);
        drive(15'b1_1_0_0_0_0_00000000_0);
        repeat (2) @(posedge clk);
        #2;
        check("R2", clk_en, 1'b0, "gated before soft reset");
        @(negedge clk);
        soft_rst_n = 1'b0;
        #1;
        check("R1", clk_en, 1'b1, "soft reset releases gate without edge");
        @(posedge clk);
        #2;
        check("R1", clk_en, 1'b1, "soft reset held");
        @(negedge clk);
        soft_rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check("R2", clk_en, 1'b0, "regated after soft reset");

        // R1: external reset releases gating asynchronously
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R1", clk_en, 1'b1, "external reset releases gate");
        @(negedge clk);
        rst = 1'b0;
        drive(15'b1_1_0_0_0_0_00000000_0);
        @(posedge clk);
        #2;
        check("R2", clk_en, 1'b1, "first edge after reset still enabled");
        @(posedge clk);
        #2;
        check("R2", clk_en, 1'b0, "second edge gated");

        // R8: snoop bypass with no edge; R4: wfi drop alone keeps gate
        @(negedge clk);
        core_wfi = 1'b0;
        snp_pend = 1'b1;
        #1;
        check("R8", clk_en, 1'b1, "snoop bypass same cycle");
        snp_pend = 1'b0;
        #1;
        check("R8", clk_en, 1'b0, "bypass ends with snoop");
        @(posedge clk);
        #2;
        check("R4", clk_en, 1'b0, "wfi drop alone does not release");
        // R5: a middle interrupt bit (supervisor external, bit 4) wakes
        @(negedge clk);
        irq_src = 8'h10;
        @(posedge clk);
        #2;
        check("R5", clk_en, 1'b0, "gate still set on wake edge");
        @(negedge clk);
        irq_src = 8'h00;
        @(posedge clk);
        #2;
        check("R5", clk_en, 1'b1, "irq bit4 wake clears gate");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule